// File: doc/BRIEF.md
# Granule-Based Queue Admission Control

This block decides, packet by packet, whether a group of egress queues may take on more data. Buffer use is counted in granules of 128 bytes. Each queue has its own programmable ceiling, and a second ceiling applies to the sum over all queues. An arriving packet gives a queue index and a byte length. The block turns the length into a granule count and compares the resulting occupancy against both ceilings. One cycle later it reports accept or drop. Accepted packets are added to the occupancy counters. A departure event gives a queue index and the byte length of the packet that left, and its granules are released from that queue and from the total.

Any arrival that would push a queue or the total past its ceiling raises a sticky interrupt flag, one per queue plus one for the aggregate. A global drop enable selects the mode. With dropping on, offending packets are discarded. With dropping off, they are still admitted and only flagged. A small write-only register port loads the ceilings and the drop enable, and clears flags by write-one. Packet storage and buffer linking are handled elsewhere.

Top module: `queue_admit_ctrl`

## Requirements
- R1: A packet of L bytes occupies ceil(L/128) granules. A zero-length packet counts as one granule. Departures are converted the same way.
- R2: An arrival in cycle N produces dec_valid, dec_qid and dec_accept in cycle N+1. The occupancy outputs reflect an accepted packet in that same cycle N+1.
- R3: An arrival is over the queue limit when that queue's occupancy plus the packet's granules exceeds the queue's 10-bit limit. A limit of 0 therefore rejects every packet. With dropping enabled, such a packet is refused and neither the queue counter nor the total changes because of it.
- R4: An arrival is over the aggregate limit when the total occupancy plus the packet's granules exceeds the 14-bit aggregate limit. With dropping enabled, such a packet is refused.
- R5: When the drop enable (bit 0 at register address 5) is 0, every arrival is accepted and counted, including those that break a limit.
- R6: A queue-limit excess sets irq_q[queue], and an aggregate excess sets irq_agg, in the cycle the decision appears, whatever the drop mode. The flags stay set until a write to address 6 with bit i = 1 clears irq_q[i], or with bit 4 = 1 clears irq_agg. A set in the same cycle as a clear wins. The irq output is the OR of all five flags.
- R7: A departure subtracts its granules from the named queue and from the total in the same cycle. An arrival and a departure in one cycle are both applied. A counter that would go below zero stops at zero.
- R8: Occupancy counters are 15 bits wide and stop at 32767 instead of wrapping.
- R9: Register writes go to address 0..3 for the queue limits (reset 1023), address 4 for the aggregate limit (reset 16383), address 5 for control (reset: drop enabled) and address 6 for flag clears. A write changes behaviour from the next cycle. Writes to address 7 have no effect.
- R10: The limit checks for an arrival use the occupancy held before any departure in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arr_valid | input | 1 | Packet arrival request |
| arr_qid | input | 2 | Target queue of the arrival |
| arr_len | input | 14 | Arrival length in bytes |
| dep_valid | input | 1 | Packet departure event |
| dep_qid | input | 2 | Queue the departing packet leaves |
| dep_len | input | 14 | Departure length in bytes |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 14 | Register write data |
| dec_valid | output | 1 | Decision present |
| dec_qid | output | 2 | Queue the decision refers to |
| dec_accept | output | 1 | 1 = admitted, 0 = dropped |
| occ_q | output | 60 | Per-queue occupancy, queue i in bits [15i+14:15i] |
| occ_total | output | 15 | Occupancy over all queues |
| irq_q | output | 4 | Sticky per-queue excess flags |
| irq_agg | output | 1 | Sticky aggregate excess flag |
| irq | output | 1 | OR of all flags |

## Verification
The assertions check on every cycle that each arrival is answered exactly one cycle later, and that a drop leaves the total unchanged when no departure intervenes. They also check that a non-dropping configuration always admits, that a zero queue limit always refuses when dropping is enabled, that every refusal comes with a raised flag, and that flags only fall after a clear write. The exact granule rounding, the occupancy arithmetic with simultaneous arrival and departure, clamping at zero and at the ceiling, and the register defaults can only be shown by the bench. It runs directed corner cases and random traffic and compares every output with its own model.

// File: rtl/qadm_pkg.sv
`timescale 1ns/1ps
// Shared types for the queue admission controller.
package qadm_pkg;

    // Which register a write addresses.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_QLIM,
        SEL_ALIM,
        SEL_CTRL,
        SEL_ICLR
    } reg_sel_e;

    // Outcome of checking one arrival against the limits.
    typedef struct packed {
        logic q_exc;
        logic a_exc;
        logic accept;
    } verdict_t;

endpackage

// File: rtl/qadm_gran_calc.sv
`timescale 1ns/1ps
// Converts a byte length into a granule count.
// Assumes GRAN_BYTES is a power of two and LEN_W exceeds its log2.
// A zero length is rounded up to one granule so that it still occupies space.
module qadm_gran_calc #(
    parameter int LEN_W      = 14,
    parameter int GRAN_BYTES = 128,
    localparam int SH        = $clog2(GRAN_BYTES),
    localparam int GR_W      = LEN_W + 1 - SH
) (
    input  logic [LEN_W-1:0] len,
    output logic [GR_W-1:0]  gran
);

    logic [GR_W-1:0] whole;
    logic            part;

    // Ceiling division: full blocks plus one for any remainder.
    always_comb begin
        whole = GR_W'(len[LEN_W-1:SH]);
        part  = |len[SH-1:0];
        if (len == '0) begin
            gran = GR_W'(1);
        end else begin
            gran = whole + GR_W'(part);
        end
    end

endmodule

// File: rtl/qadm_cfg_regs.sv
`timescale 1ns/1ps
// Write-only configuration registers: per-queue limits, aggregate limit,
// drop enable, and a one-cycle flag-clear mask from write-one-to-clear.
// Assumes DATA_W >= AGG_W, DATA_W >= LIM_W and DATA_W > NUM_Q, and that
// the address space holds NUM_Q + 3 locations.
module qadm_cfg_regs
    import qadm_pkg::*;
#(
    parameter int NUM_Q  = 4,
    parameter int LIM_W  = 10,
    parameter int AGG_W  = 14,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [NUM_Q*LIM_W-1:0] lim_flat,
    output logic [AGG_W-1:0]       agg_lim,
    output logic                   drop_en,
    output logic [NUM_Q:0]         clr_mask
);

    localparam int ALIM_ADDR = NUM_Q;
    localparam int CTRL_ADDR = NUM_Q + 1;
    localparam int ICLR_ADDR = NUM_Q + 2;

    reg_sel_e sel;

    // Classify the write address.
    always_comb begin
        sel = SEL_NONE;
        if (wr) begin
            if (addr < ADDR_W'(NUM_Q))              sel = SEL_QLIM;
            else if (addr == ADDR_W'(ALIM_ADDR))    sel = SEL_ALIM;
            else if (addr == ADDR_W'(CTRL_ADDR))    sel = SEL_CTRL;
            else if (addr == ADDR_W'(ICLR_ADDR))    sel = SEL_ICLR;
        end
    end

    // One limit register per queue.
    for (genvar i = 0; i < NUM_Q; i++) begin : g_qlim
        logic [LIM_W-1:0] lim_r;

        // Load this queue's limit when its address is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lim_r <= '1;
            end else if (sel == SEL_QLIM && addr == ADDR_W'(i)) begin
                lim_r <= wdata[LIM_W-1:0];
            end
        end

        assign lim_flat[i*LIM_W +: LIM_W] = lim_r;
    end

    // Aggregate limit and drop enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            agg_lim <= '1;
            drop_en <= 1'b1;
        end else begin
            if (sel == SEL_ALIM) agg_lim <= wdata[AGG_W-1:0];
            if (sel == SEL_CTRL) drop_en <= wdata[0];
        end
    end

    // Clear strobes are valid only in the cycle of the write.
    assign clr_mask = (sel == SEL_ICLR) ? wdata[NUM_Q:0] : '0;

endmodule

// File: rtl/qadm_occ_track.sv
`timescale 1ns/1ps
// Per-queue and aggregate occupancy counters in granules.
// An admitted arrival and a departure may land in the same cycle;
// both are applied. Counters clamp at zero and at their maximum.
module qadm_occ_track #(
    parameter int NUM_Q = 4,
    parameter int OCC_W = 15,
    parameter int GR_W  = 8,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   add_en,
    input  logic [QW-1:0]          add_q,
    input  logic [GR_W-1:0]        add_gr,
    input  logic                   sub_en,
    input  logic [QW-1:0]          sub_q,
    input  logic [GR_W-1:0]        sub_gr,
    output logic [NUM_Q*OCC_W-1:0] occ_flat,
    output logic [OCC_W-1:0]       occ_total
);

    localparam int CW = OCC_W + 1;

    // Next counter value with both-sided saturation.
    function automatic logic [OCC_W-1:0] step_cnt(
        input logic [OCC_W-1:0] old,
        input logic [GR_W-1:0]  add,
        input logic [GR_W-1:0]  sub
    );
        logic [CW-1:0] sum;
        logic [CW-1:0] diff;
        sum = {1'b0, old} + CW'(add);
        if (sum < CW'(sub)) begin
            return '0;
        end
        diff = sum - CW'(sub);
        if (diff[OCC_W]) begin
            return '1;
        end
        return diff[OCC_W-1:0];
    endfunction

    for (genvar i = 0; i < NUM_Q; i++) begin : g_cnt
        logic [OCC_W-1:0] cnt_r;
        logic [GR_W-1:0]  a_i;
        logic [GR_W-1:0]  s_i;

        assign a_i = (add_en && add_q == QW'(i)) ? add_gr : '0;
        assign s_i = (sub_en && sub_q == QW'(i)) ? sub_gr : '0;

        // Apply this queue's share of the arrival and departure.
        always_ff @(posedge clk) begin
            if (!rst_n) cnt_r <= '0;
            else        cnt_r <= step_cnt(cnt_r, a_i, s_i);
        end

        assign occ_flat[i*OCC_W +: OCC_W] = cnt_r;
    end

    logic [GR_W-1:0] a_all;
    logic [GR_W-1:0] s_all;

    assign a_all = add_en ? add_gr : '0;
    assign s_all = sub_en ? sub_gr : '0;

    // Aggregate counter sees every arrival and departure.
    always_ff @(posedge clk) begin
        if (!rst_n) occ_total <= '0;
        else        occ_total <= step_cnt(occ_total, a_all, s_all);
    end

endmodule

// File: rtl/qadm_judge.sv
`timescale 1ns/1ps
// Checks one arrival against its queue limit and the aggregate limit,
// forms the admit verdict, keeps the sticky excess flags and registers
// the decision. Uses the counts held before this cycle's departure.
module qadm_judge
    import qadm_pkg::*;
#(
    parameter int NUM_Q = 4,
    parameter int LIM_W = 10,
    parameter int AGG_W = 14,
    parameter int OCC_W = 15,
    parameter int GR_W  = 8,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arr_valid,
    input  logic [QW-1:0]          arr_q,
    input  logic [GR_W-1:0]        arr_gr,
    input  logic [NUM_Q*OCC_W-1:0] occ_flat,
    input  logic [OCC_W-1:0]       occ_total,
    input  logic [NUM_Q*LIM_W-1:0] lim_flat,
    input  logic [AGG_W-1:0]       agg_lim,
    input  logic                   drop_en,
    input  logic [NUM_Q:0]         clr_mask,
    output logic                   admit,
    output logic                   dec_valid,
    output logic [QW-1:0]          dec_q,
    output logic                   dec_accept,
    output logic [NUM_Q-1:0]       irq_q,
    output logic                   irq_agg
);

    localparam int CW = OCC_W + 1;

    logic [OCC_W-1:0] occ_sel;
    logic [LIM_W-1:0] lim_sel;
    logic [CW-1:0]    q_need;
    logic [CW-1:0]    a_need;
    verdict_t         v;

    // Compare prospective occupancy against both limits.
    always_comb begin
        occ_sel  = occ_flat[arr_q*OCC_W +: OCC_W];
        lim_sel  = lim_flat[arr_q*LIM_W +: LIM_W];
        q_need   = {1'b0, occ_sel} + CW'(arr_gr);
        a_need   = {1'b0, occ_total} + CW'(arr_gr);
        v.q_exc  = arr_valid && (q_need > CW'(lim_sel));
        v.a_exc  = arr_valid && (a_need > CW'(agg_lim));
        v.accept = arr_valid && (!(v.q_exc || v.a_exc) || !drop_en);
    end

    assign admit = v.accept;

    for (genvar i = 0; i < NUM_Q; i++) begin : g_flag
        // Sticky queue flag; a new excess outranks a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q[i] <= 1'b0;
            else        irq_q[i] <= (irq_q[i] && !clr_mask[i]) ||
                                    (v.q_exc && arr_q == QW'(i));
        end
    end

    // Sticky aggregate flag, same priority rule.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_agg <= 1'b0;
        else        irq_agg <= (irq_agg && !clr_mask[NUM_Q]) || v.a_exc;
    end

    // Registered decision, one cycle after the arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_q      <= '0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= arr_valid;
            dec_q      <= arr_q;
            dec_accept <= v.accept;
        end
    end

endmodule

// File: rtl/queue_admit_ctrl.sv
`timescale 1ns/1ps
// Admission control for a group of egress queues, counted in granules.
// Arrivals are judged against per-queue and aggregate limits. Departures
// release granules. Excess events set sticky flags.
// Assumes departure lengths match the lengths of packets that were admitted.
module queue_admit_ctrl #(
    parameter int NUM_Q      = 4,
    parameter int LEN_W      = 14,
    parameter int GRAN_BYTES = 128,
    parameter int LIM_W      = 10,
    parameter int AGG_W      = 14,
    parameter int ADDR_W     = 3,
    localparam int QW        = $clog2(NUM_Q),
    localparam int OCC_W     = AGG_W + 1,
    localparam int DATA_W    = AGG_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arr_valid,
    input  logic [QW-1:0]          arr_qid,
    input  logic [LEN_W-1:0]       arr_len,
    input  logic                   dep_valid,
    input  logic [QW-1:0]          dep_qid,
    input  logic [LEN_W-1:0]       dep_len,
    input  logic                   cfg_wr,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]      cfg_wdata,
    output logic                   dec_valid,
    output logic [QW-1:0]          dec_qid,
    output logic                   dec_accept,
    output logic [NUM_Q*OCC_W-1:0] occ_q,
    output logic [OCC_W-1:0]       occ_total,
    output logic [NUM_Q-1:0]       irq_q,
    output logic                   irq_agg,
    output logic                   irq
);

    localparam int GR_W = LEN_W + 1 - $clog2(GRAN_BYTES);

    logic [GR_W-1:0]        arr_gr;
    logic [GR_W-1:0]        dep_gr;
    logic [NUM_Q*LIM_W-1:0] lim_w;
    logic [AGG_W-1:0]       agg_lim_w;
    logic                   drop_en_w;
    logic [NUM_Q:0]         clr_w;
    logic                   admit_w;

    qadm_gran_calc #(.LEN_W(LEN_W), .GRAN_BYTES(GRAN_BYTES)) u_arr_gran (
        .len  (arr_len),
        .gran (arr_gr)
    );

    qadm_gran_calc #(.LEN_W(LEN_W), .GRAN_BYTES(GRAN_BYTES)) u_dep_gran (
        .len  (dep_len),
        .gran (dep_gr)
    );

    qadm_cfg_regs #(
        .NUM_Q(NUM_Q), .LIM_W(LIM_W), .AGG_W(AGG_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .lim_flat (lim_w),
        .agg_lim  (agg_lim_w),
        .drop_en  (drop_en_w),
        .clr_mask (clr_w)
    );

    qadm_judge #(
        .NUM_Q(NUM_Q), .LIM_W(LIM_W), .AGG_W(AGG_W),
        .OCC_W(OCC_W), .GR_W(GR_W)
    ) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .arr_valid  (arr_valid),
        .arr_q      (arr_qid),
        .arr_gr     (arr_gr),
        .occ_flat   (occ_q),
        .occ_total  (occ_total),
        .lim_flat   (lim_w),
        .agg_lim    (agg_lim_w),
        .drop_en    (drop_en_w),
        .clr_mask   (clr_w),
        .admit      (admit_w),
        .dec_valid  (dec_valid),
        .dec_q      (dec_qid),
        .dec_accept (dec_accept),
        .irq_q      (irq_q),
        .irq_agg    (irq_agg)
    );

    qadm_occ_track #(.NUM_Q(NUM_Q), .OCC_W(OCC_W), .GR_W(GR_W)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_en    (admit_w),
        .add_q     (arr_qid),
        .add_gr    (arr_gr),
        .sub_en    (dep_valid),
        .sub_q     (dep_qid),
        .sub_gr    (dep_gr),
        .occ_flat  (occ_q),
        .occ_total (occ_total)
    );

    // Combined interrupt line.
    assign irq = (|irq_q) || irq_agg;

endmodule

// File: rtl/qadm_chk.sv
`timescale 1ns/1ps
// Property checker for queue_admit_ctrl, attached by bind below.
module qadm_chk #(
    parameter int NUM_Q = 4,
    parameter int LIM_W = 10,
    parameter int OCC_W = 15,
    localparam int QW   = $clog2(NUM_Q)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   arr_valid,
    input logic [QW-1:0]          arr_qid,
    input logic                   dep_valid,
    input logic                   drop_en,
    input logic [NUM_Q*LIM_W-1:0] lim_flat,
    input logic [NUM_Q:0]         clr_mask,
    input logic                   dec_valid,
    input logic [QW-1:0]          dec_qid,
    input logic                   dec_accept,
    input logic [OCC_W-1:0]       occ_total,
    input logic [NUM_Q-1:0]       irq_q,
    input logic                   irq_agg
);

    // R2: every arrival gets a decision on the next cycle.
    p_dec_follows_arr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_valid |=> dec_valid);

    // R2: no decision without an arrival.
    p_no_spurious_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !arr_valid |=> !dec_valid);

    // R3: a dropped packet leaves the total untouched.
    p_drop_keeps_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept && !$past(dep_valid)) |-> occ_total == $past(occ_total));

    // R3: a zero queue limit refuses everything while dropping.
    p_zero_limit_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && drop_en && lim_flat[arr_qid*LIM_W +: LIM_W] == '0) |=> !dec_accept);

    // R5: with dropping disabled everything is admitted.
    p_nodrop_admits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_valid && !drop_en) |=> dec_accept);

    // R6: every refusal is accompanied by a raised flag.
    p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> (irq_q[dec_qid] || irq_agg));

    for (genvar i = 0; i < NUM_Q; i++) begin : g_sticky
        // R6: a queue flag only falls after a clear write.
        p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_q[i]) |-> $past(clr_mask[i]));
    end

    // R6: the aggregate flag only falls after a clear write.
    p_agg_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_agg) |-> $past(clr_mask[NUM_Q]));

endmodule

bind queue_admit_ctrl qadm_chk #(
    .NUM_Q(NUM_Q), .LIM_W(LIM_W), .OCC_W(OCC_W)
) u_qadm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arr_valid  (arr_valid),
    .arr_qid    (arr_qid),
    .dep_valid  (dep_valid),
    .drop_en    (drop_en_w),
    .lim_flat   (lim_w),
    .clr_mask   (clr_w),
    .dec_valid  (dec_valid),
    .dec_qid    (dec_qid),
    .dec_accept (dec_accept),
    .occ_total  (occ_total),
    .irq_q      (irq_q),
    .irq_agg    (irq_agg)
);

// File: tb/queue_admit_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random traffic,
// compared each cycle against a model built from the requirements.
module queue_admit_ctrl_bench;

    localparam int NQ      = 4;
    localparam int LEN_W   = 14;
    localparam int AW      = 3;
    localparam int DW      = 14;
    localparam int OCC_W   = 15;
    localparam int QW      = 2;
    localparam int OCC_MAX = (1 << OCC_W) - 1;

    logic              clk;
    logic              rst_n;
    logic              arr_valid;
    logic [QW-1:0]     arr_qid;
    logic [LEN_W-1:0]  arr_len;
    logic              dep_valid;
    logic [QW-1:0]     dep_qid;
    logic [LEN_W-1:0]  dep_len;
    logic              cfg_wr;
    logic [AW-1:0]     cfg_addr;
    logic [DW-1:0]     cfg_wdata;
    logic              dec_valid;
    logic [QW-1:0]     dec_qid;
    logic              dec_accept;
    logic [NQ*OCC_W-1:0] occ_q;
    logic [OCC_W-1:0]  occ_total;
    logic [NQ-1:0]     irq_q;
    logic              irq_agg;
    logic              irq;

    queue_admit_ctrl u_queue_admit_ctrl (
        .clk(clk), .rst_n(rst_n),
        .arr_valid(arr_valid), .arr_qid(arr_qid), .arr_len(arr_len),
        .dep_valid(dep_valid), .dep_qid(dep_qid), .dep_len(dep_len),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dec_valid(dec_valid), .dec_qid(dec_qid), .dec_accept(dec_accept),
        .occ_q(occ_q), .occ_total(occ_total),
        .irq_q(irq_q), .irq_agg(irq_agg), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Model state
    int         m_occ [NQ];
    int         m_tot;
    int         m_lim [NQ];
    int         m_alim;
    bit         m_drop;
    bit [NQ:0]  m_irq;

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R2 watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic int gran(int len);
        if (len == 0) return 1;          // R1 zero length
        return (len + 127) / 128;        // R1 ceiling
    endfunction

    function automatic int upd(int old, int add, int sub);
        int s;
        s = old + add;
        if (s < sub) return 0;           // R7 clamp at zero
        s = s - sub;
        if (s > OCC_MAX) return OCC_MAX; // R8 saturation
        return s;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int occ_of(int i);
        return int'(occ_q[i*OCC_W +: OCC_W]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NQ; i++) begin
            m_occ[i] = 0;
            m_lim[i] = 1023;             // R9 reset limit
        end
        m_tot  = 0;
        m_alim = 16383;                  // R9 reset aggregate limit
        m_drop = 1'b1;                   // R9 dropping on after reset
        m_irq  = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        arr_valid = 0; dep_valid = 0; cfg_wr = 0;
        arr_qid = 0; arr_len = 0; dep_qid = 0; dep_len = 0;
        cfg_addr = 0; cfg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk("R2 reset dec_valid", dec_valid, 0);
        chk("R6 reset irq", irq, 0);
        chk("R7 reset occ_total", occ_total, 0);
        for (int i = 0; i < NQ; i++) chk("R7 reset occ_q", occ_of(i), 0);
    endtask

    // One cycle: drive at negedge, advance the model, compare at next negedge.
    task automatic step(bit a, int aq, int alen, bit d, int dq, int dlen,
                        bit w, int addr, int data, string tag);
        int g, gd, add, sub;
        bit qe, ae, acc;
        bit [NQ:0] clr, setm;
        arr_valid = a;  arr_qid = QW'(aq);  arr_len = LEN_W'(alen);
        dep_valid = d;  dep_qid = QW'(dq);  dep_len = LEN_W'(dlen);
        cfg_wr = w;     cfg_addr = AW'(addr); cfg_wdata = DW'(data);

        g  = gran(alen);
        gd = gran(dlen);
        qe = a && (m_occ[aq] + g > m_lim[aq]);     // R3, R10
        ae = a && (m_tot + g > m_alim);            // R4, R10
        acc = a && (!(qe || ae) || !m_drop);       // R5
        for (int i = 0; i < NQ; i++) begin
            add = (acc && aq == i) ? g : 0;
            sub = (d && dq == i) ? gd : 0;
            m_occ[i] = upd(m_occ[i], add, sub);
        end
        m_tot = upd(m_tot, acc ? g : 0, d ? gd : 0);
        clr  = (w && addr == 6) ? data[NQ:0] : '0;
        setm = '0;
        if (qe) setm[aq] = 1'b1;
        setm[NQ] = ae;
        m_irq = (m_irq & ~clr) | setm;             // R6 set wins
        if (w) begin                               // R9 map
            if (addr < NQ)       m_lim[addr] = data & 1023;
            else if (addr == 4)  m_alim = data & 16383;
            else if (addr == 5)  m_drop = data[0];
        end

        @(posedge clk);
        @(negedge clk);
        chk({tag, " R2 dec_valid"}, dec_valid, a);
        if (a) begin
            chk({tag, " R2 dec_qid"}, dec_qid, aq);
            chk({tag, " R3 R4 R5 dec_accept"}, dec_accept, acc);
        end
        for (int i = 0; i < NQ; i++) chk({tag, " R7 occ_q"}, occ_of(i), m_occ[i]);
        chk({tag, " R7 occ_total"}, occ_total, m_tot);
        chk({tag, " R6 irq_q"}, irq_q, m_irq[NQ-1:0]);
        chk({tag, " R6 irq_agg"}, irq_agg, m_irq[NQ]);
        chk({tag, " R6 irq"}, irq, |m_irq);
    endtask

    task automatic arrive(int q, int len, string tag);
        step(1, q, len, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wreg(int addr, int data, string tag);
        step(0, 0, 0, 0, 0, 0, 1, addr, data, tag);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0;
        do_reset();

        // R1: rounding of lengths 0, 128, 129 under default limits (R9)
        arrive(1, 0,   "R1 len0");
        chk("R1 zero length is one granule", occ_of(1), 1);
        arrive(1, 128, "R1 len128");
        arrive(1, 129, "R1 len129");
        chk("R1 129 bytes is two granules", occ_of(1), 4);

        // R3: queue limit of 3 granules
        wreg(2, 3, "R9 set q2 limit");
        arrive(2, 384, "R3 fill to limit");
        chk("R3 exact fit accepted", dec_accept, 1);
        arrive(2, 1, "R3 over limit");
        chk("R3 over limit dropped", dec_accept, 0);
        chk("R3 drop leaves count", occ_of(2), 3);

        // R3: zero limit rejects even the smallest packet
        wreg(3, 0, "R3 zero limit");
        arrive(3, 0, "R3 zero limit arrival");
        chk("R3 zero limit dropped", dec_accept, 0);

        // R6: clear and set-wins-over-clear
        wreg(6, 5'b01000, "R6 clear q3");
        chk("R6 q3 cleared", irq_q[3], 0);
        step(1, 3, 10, 0, 0, 0, 1, 6, 5'b01000, "R6 set wins");
        chk("R6 set beats clear", irq_q[3], 1);

        // R4: aggregate limit
        wreg(4, m_tot + 2, "R9 set aggregate");
        arrive(0, 256, "R4 fits aggregate");
        arrive(0, 1, "R4 over aggregate");
        chk("R4 aggregate drop", dec_accept, 0);
        chk("R4 aggregate flag", irq_agg, 1);

        // R5: dropping off admits and still flags
        wreg(5, 0, "R5 drop off");
        arrive(2, 1000, "R5 over both limits");
        chk("R5 admitted despite excess", dec_accept, 1);

        // R9: address 7 has no effect
        wreg(7, 16383, "R9 unused address");
        wreg(5, 1, "R5 drop on");

        // R7 R10: arrival and departure together; decision on old count
        step(1, 2, 1, 1, 2, 384, 0, 0, 0, "R10 same cycle");
        step(0, 0, 0, 1, 1, 16383, 0, 0, 0, "R7 clamp zero");
        chk("R7 clamped at zero", occ_of(1), 0);

        // R8: saturation with dropping off
        do_reset();
        wreg(5, 0, "R8 drop off");
        for (int n = 0; n < 260; n++) arrive(0, 16383, "R8 fill");
        chk("R8 queue saturates", occ_of(0), OCC_MAX);
        for (int n = 0; n < 5; n++) step(0, 0, 0, 1, 0, 16383, 0, 0, 0, "R8 release");

        // Random traffic
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            int r, addr, data;
            r = $urandom_range(0, 99);
            if (r < 8) begin
                addr = $urandom_range(0, 7);
                if (addr < 4)       data = $urandom_range(0, 80);
                else if (addr == 4) data = $urandom_range(0, 250);
                else if (addr == 5) data = ($urandom_range(0, 3) != 0) ? 1 : 0;
                else                data = $urandom_range(0, 31);
                step($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 1500),
                     0, 0, 0, 1, addr, data, "rand cfg");
            end else begin
                step(r < 70, $urandom_range(0, 3),
                     ($urandom_range(0, 19) == 0) ? 16383 : $urandom_range(0, 1500),
                     $urandom_range(0, 2) == 0, $urandom_range(0, 3),
                     $urandom_range(0, 1500), 0, 0, 0, "rand traffic");
            end
        end

        arr_valid = 0; dep_valid = 0; cfg_wr = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule